// File: doc/BRIEF.md
# Pulse Termination Latch and Dual Gate Steering

This block is the digital back end of a switching regulator controller. An oscillator deadtime strobe splits time into cycles. While the strobe is high, both gate outputs are low and the pulse latch clears. When the strobe falls, a new on-period begins. It ends at the first clock that samples a ramp comparator trip, a current-limit trip or the fault indication. From then on the latch holds the outputs low until the next deadtime. While a programmable number of clocks runs at the start of each on-period, the current-limit trip is masked so that the turn-on spike does not end the pulse.

The surviving pulse is steered to two gate outputs. A static mode input selects one of four behaviours:
- Alternating: a toggle advanced by each deadtime sends successive pulses to A and B in turn.
- In-phase: both outputs carry the same pulse.
- Complementary: A carries the pulse, and B drives the rest of the on-period after a counted gap.
- Quiet: both outputs stay low.

All inputs are single-bit strobes that are synchronous to the system clock. Every output is registered. The output seen after a clock edge reflects the inputs sampled at that edge. No input or output carries a data stream, so there is no valid/ready interface and no back-pressure: every pin is plain control.

Top module: `pwm_pulse_steer`

## Requirements
- R1: During reset both outputs are low. After reset, no pulse appears until the first clock that samples `osc_dead` high.
- R2: An edge that samples `osc_dead` high drives both outputs low after that edge. It also clears the pulse latch, so the next on-period starts unterminated.
- R3: An edge that samples `cmp_trip` high drives the pulse low after that edge. The pulse stays low for the rest of the on-period even after `cmp_trip` returns low.
- R4: `ilim_trip` is ignored on the first `blank_len` clocks of each on-period (active indices 0 to `blank_len`-1). From index `blank_len` on, it terminates the pulse exactly like R3.
- R5: `fault_hold` high drives both outputs low after the sampling edge. It also terminates the rest of the on-period.
- R6: `mode` = 2'b00 (alternating): the first cycle after reset steers its pulse to A. Each further deadtime swaps the target, and the other output stays low.
- R7: `mode` = 2'b01 (in-phase): A and B are identical on every clock.
- R8: `mode` = 2'b10 (complementary): A carries the pulse. B rises exactly `gap_len`+1 clocks after A falls and stays high until the next deadtime. A and B are never high together.
- R9: `mode` = 2'b11: both outputs stay low.
- R10: Outputs are registered. The value after an edge depends only on the latch state and on the inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Steering mode: 00 alternating, 01 in-phase, 10 complementary, 11 quiet |
| gap_len | input | GAP_W | Complementary gap in clocks, counted after the latch sets |
| blank_len | input | BLANK_W | Number of on-period clocks that mask the current-limit trip |
| osc_dead | input | 1 | Oscillator deadtime strobe (high = deadtime) |
| cmp_trip | input | 1 | Ramp comparator trip |
| ilim_trip | input | 1 | Cycle-by-cycle current-limit trip |
| fault_hold | input | 1 | Fault latch state; holds outputs low |
| out_a | output | 1 | Gate output A |
| out_b | output | 1 | Gate output B |

## Verification
The properties assume four things about the inputs:
- `mode`, `gap_len` and `blank_len` change only while `osc_dead` is high.
- Every deadtime lasts at least one clock, so the blanking counter reloads.
- The trip strobes are clean synchronous levels.
- After reset, `osc_dead` does not rise in the very first clock.

Under these assumptions, the properties check the deadtime-low, fault-low, trip-cut, mode-exclusivity and no-overlap rules on every clock. The stimulus meets the same assumptions: it drives inputs on the falling clock edge, changes the mode only as a deadtime begins, holds each deadtime for four clocks, and gives each trip as a one-clock strobe at a chosen index of a twenty-clock on-period.

// File: rtl/pws_pkg.sv
package pws_pkg;

  typedef enum logic [1:0] {
    STEER_ALT  = 2'b00,
    STEER_SAME = 2'b01,
    STEER_COMP = 2'b10,
    STEER_OFF  = 2'b11
  } steer_mode_e;

endpackage

// File: rtl/pws_phase.sv
// Tracks the deadtime strobe: marks the block live after the first
// deadtime and flips the steering toggle on every deadtime rising edge.
module pws_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_dead,
  output logic live,
  output logic steer_b
);

  logic dead_q;
  logic live_q;
  logic steer_q;
  logic dead_rise;

  assign dead_rise = osc_dead & ~dead_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q  <= 1'b0;
      live_q  <= 1'b0;
      steer_q <= 1'b1;   // first flip lands on A
    end else begin
      dead_q <= osc_dead;
      if (osc_dead) live_q <= 1'b1;
      if (dead_rise) steer_q <= ~steer_q;
    end
  end

  assign live    = live_q;
  assign steer_b = steer_q;

endmodule

// File: rtl/pws_term.sv
// Pulse termination latch with a leading-edge blanking counter.
module pws_term #(
  parameter int BLANK_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_dead,
  input  logic               cmp_trip,
  input  logic               ilim_trip,
  input  logic               fault_hold,
  input  logic [BLANK_W-1:0] blank_len,
  output logic               gate,
  output logic               term_q
);

  localparam logic [BLANK_W-1:0] BLANK_ZERO = '0;

  logic [BLANK_W-1:0] blank_cnt;
  logic               blanking;
  logic               trip_now;
  logic               latch_q;

  assign blanking = (blank_cnt != BLANK_ZERO);
  assign trip_now = cmp_trip | (ilim_trip & ~blanking) | fault_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blank_cnt <= BLANK_ZERO;
    end else if (osc_dead) begin
      blank_cnt <= blank_len;
    end else if (blanking) begin
      blank_cnt <= blank_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
    end else if (osc_dead) begin
      latch_q <= 1'b0;
    end else if (trip_now) begin
      latch_q <= 1'b1;
    end
  end

  assign gate   = ~osc_dead & ~latch_q & ~trip_now;
  assign term_q = latch_q;

endmodule

// File: rtl/pws_gap.sv
// Counts clocks since the pulse latch set; reports when the gap is spent.
module pws_gap #(
  parameter int GAP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             osc_dead,
  input  logic             term_q,
  input  logic [GAP_W-1:0] gap_len,
  output logic             gap_done
);

  logic [GAP_W-1:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= '0;
    end else if (osc_dead) begin
      gap_cnt <= '0;
    end else if (term_q && (gap_cnt != gap_len)) begin
      gap_cnt <= gap_cnt + 1'b1;
    end
  end

  assign gap_done = term_q & (gap_cnt == gap_len);

endmodule

// File: rtl/pwm_pulse_steer.sv
module pwm_pulse_steer #(
  parameter int GAP_W   = 6,
  parameter int BLANK_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic [GAP_W-1:0]   gap_len,
  input  logic [BLANK_W-1:0] blank_len,
  input  logic               osc_dead,
  input  logic               cmp_trip,
  input  logic               ilim_trip,
  input  logic               fault_hold,
  output logic               out_a,
  output logic               out_b
);

  import pws_pkg::*;

  steer_mode_e sel;
  logic live, steer_b, gate, term_q, gap_done;
  logic pulse, tail;
  logic a_next, b_next;
  logic a_q, b_q;

  assign sel = steer_mode_e'(mode);

  pws_phase u_phase (
    .clk(clk), .rst_n(rst_n), .osc_dead(osc_dead),
    .live(live), .steer_b(steer_b)
  );

  pws_term #(.BLANK_W(BLANK_W)) u_term (
    .clk(clk), .rst_n(rst_n), .osc_dead(osc_dead),
    .cmp_trip(cmp_trip), .ilim_trip(ilim_trip), .fault_hold(fault_hold),
    .blank_len(blank_len), .gate(gate), .term_q(term_q)
  );

  pws_gap #(.GAP_W(GAP_W)) u_gap (
    .clk(clk), .rst_n(rst_n), .osc_dead(osc_dead),
    .term_q(term_q), .gap_len(gap_len), .gap_done(gap_done)
  );

  // Main pulse and complementary tail, both gated by liveness and fault.
  assign pulse = live & gate & ~fault_hold;
  assign tail  = live & ~osc_dead & ~fault_hold & gap_done;

  always_comb begin
    a_next = 1'b0;
    b_next = 1'b0;
    case (sel)
      STEER_ALT: begin
        a_next = pulse & ~steer_b;
        b_next = pulse &  steer_b;
      end
      STEER_SAME: begin
        a_next = pulse;
        b_next = pulse;
      end
      STEER_COMP: begin
        a_next = pulse;
        b_next = tail;
      end
      default: begin
        a_next = 1'b0;
        b_next = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_next;
      b_q <= b_next;
    end
  end

  assign out_a = a_q;
  assign out_b = b_q;

endmodule

// File: rtl/pws_checker.sv
module pws_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       osc_dead,
  input logic       cmp_trip,
  input logic       fault_hold,
  input logic       out_a,
  input logic       out_b
);

  a_r2_dead_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(osc_dead) |-> (!out_a && !out_b));

  a_r5_fault_low: assert property (@(posedge clk) disable iff (!rst_n)
    $past(fault_hold) |-> (!out_a && !out_b));

  a_r3_trip_cut: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_trip) |-> !out_a);

  a_r6_alt_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b00) |-> !(out_a && out_b));

  a_r7_same_equal: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b01) |-> (out_a == out_b));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b10) |-> !(out_a && out_b));

  a_r8_b_after_a_low: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(mode) == 2'b10) && $rose(out_b)) |-> $past(!out_a));

  a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode) == 2'b11) |-> (!out_a && !out_b));

endmodule

bind pwm_pulse_steer pws_checker u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .osc_dead(osc_dead),
  .cmp_trip(cmp_trip), .fault_hold(fault_hold),
  .out_a(out_a), .out_b(out_b)
);

// File: tb/pwm_pulse_steer_tb.sv
`timescale 1ns/1ps
module pwm_pulse_steer_tb;

  localparam int ACT  = 20;
  localparam int DEAD = 4;
  localparam int GAP  = 2;
  localparam int BLNK = 3;
  localparam int NONE = 255;

  typedef struct packed {
    logic [1:0] md;
    logic [7:0] cmp_at;
    logic [7:0] ilim_at;
    logic [7:0] exp_a;
    logic [7:0] exp_b;
  } vec_t;

  localparam int NV = 13;
  // cycle numbers in comments; alternating target is A on odd cycles (R6)
  localparam vec_t VEC [NV] = '{
    '{2'b00, 8'd8,   8'd255, 8'd8,  8'd0 },  // c1  R6 A, R3 cut at 8
    '{2'b00, 8'd12,  8'd255, 8'd0,  8'd12},  // c2  R6 B
    '{2'b00, 8'd255, 8'd255, 8'd20, 8'd0 },  // c3  R10 full on-period
    '{2'b00, 8'd10,  8'd1,   8'd0,  8'd10},  // c4  R4 ilim blanked
    '{2'b00, 8'd255, 8'd5,   8'd5,  8'd0 },  // c5  R4 ilim honoured
    '{2'b01, 8'd7,   8'd255, 8'd7,  8'd7 },  // c6  R7
    '{2'b01, 8'd255, 8'd255, 8'd20, 8'd20},  // c7  R7
    '{2'b10, 8'd6,   8'd255, 8'd6,  8'd11},  // c8  R8 gap 2
    '{2'b10, 8'd255, 8'd255, 8'd20, 8'd0 },  // c9  R8 no tail
    '{2'b10, 8'd0,   8'd255, 8'd0,  8'd17},  // c10 R8 immediate trip
    '{2'b11, 8'd5,   8'd255, 8'd0,  8'd0 },  // c11 R9
    '{2'b00, 8'd255, 8'd2,   8'd0,  8'd20},  // c12 R4 last blanked index
    '{2'b00, 8'd255, 8'd3,   8'd3,  8'd0 }   // c13 R4 first honoured index
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [5:0] gap_len = 6'(GAP);
  logic [5:0] blank_len = 6'(BLNK);
  logic       osc_dead = 1'b0;
  logic       cmp_trip = 1'b0;
  logic       ilim_trip = 1'b0;
  logic       fault_hold = 1'b0;
  logic       out_a, out_b;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int cnt_a, cnt_b, cnt_dead, a_fall, b_rise, overlap;

  pwm_pulse_steer #(.GAP_W(6), .BLANK_W(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .gap_len(gap_len),
    .blank_len(blank_len), .osc_dead(osc_dead), .cmp_trip(cmp_trip),
    .ilim_trip(ilim_trip), .fault_hold(fault_hold),
    .out_a(out_a), .out_b(out_b)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<20000", cyc);
      finish_run();
    end
  end

  // One oscillator cycle: deadtime then on-period with optional strobes.
  task automatic run_cycle(input logic [1:0] md, input int cmp_at,
                           input int ilim_at, input int f_from, input int f_to);
    int prev_a, prev_b;
    cnt_a = 0; cnt_b = 0; cnt_dead = 0; a_fall = -1; b_rise = -1; overlap = 0;
    for (int i = 0; i < DEAD; i++) begin
      @(negedge clk);
      if (i == 0) mode = md;
      osc_dead = 1'b1; cmp_trip = 1'b0; ilim_trip = 1'b0; fault_hold = 1'b0;
      @(posedge clk); #1;
      cnt_dead += int'(out_a) + int'(out_b);
    end
    prev_a = 0; prev_b = 0;
    for (int i = 0; i < ACT; i++) begin
      @(negedge clk);
      osc_dead   = 1'b0;
      cmp_trip   = (i == cmp_at);
      ilim_trip  = (i == ilim_at);
      fault_hold = (i >= f_from) && (i <= f_to);
      @(posedge clk); #1;
      cnt_a += int'(out_a);
      cnt_b += int'(out_b);
      if (out_a && out_b) overlap++;
      if (prev_a == 1 && !out_a && a_fall < 0) a_fall = i;
      if (prev_b == 0 && out_b && b_rise < 0) b_rise = i;
      prev_a = int'(out_a);
      prev_b = int'(out_b);
    end
    @(negedge clk);
    cmp_trip = 1'b0; ilim_trip = 1'b0; fault_hold = 1'b0;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset out_a", int'(out_a), 0);
    check("R1 reset out_b", int'(out_b), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: no pulse before the first deadtime
    cnt_a = 0; cnt_b = 0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); #1;
      cnt_a += int'(out_a);
      cnt_b += int'(out_b);
    end
    check("R1 pre-deadtime out_a", cnt_a, 0);
    check("R1 pre-deadtime out_b", cnt_b, 0);

    for (int v = 0; v < NV; v++) begin
      run_cycle(VEC[v].md, int'(VEC[v].cmp_at), int'(VEC[v].ilim_at), NONE, NONE);
      check($sformatf("R2 deadtime highs vec%0d", v), cnt_dead, 0);
      check($sformatf("R3/R4/R6-R10 A count vec%0d", v), cnt_a, int'(VEC[v].exp_a));
      check($sformatf("R3/R4/R6-R10 B count vec%0d", v), cnt_b, int'(VEC[v].exp_b));
      if (VEC[v].md == 2'b10) begin
        check($sformatf("R8 overlap vec%0d", v), overlap, 0);
        if (a_fall >= 0)
          check($sformatf("R8 gap vec%0d", v), b_rise - a_fall, GAP + 1);
      end
    end

    // R5: one-clock fault at index 4 (cycle 14, target B)
    run_cycle(2'b00, NONE, NONE, 4, 4);
    check("R5 fault cut A", cnt_a, 0);
    check("R5 fault cut B", cnt_b, 4);
    // R5: fault over the whole on-period (cycle 15, target A)
    run_cycle(2'b00, NONE, NONE, 0, ACT);
    check("R5 fault held A", cnt_a, 0);
    check("R5 fault held B", cnt_b, 0);
    // R2: deadtime clears the latch, full pulse resumes (cycle 16, B)
    run_cycle(2'b00, NONE, NONE, NONE, NONE);
    check("R2 recovery A", cnt_a, 0);
    check("R2 recovery B", cnt_b, 20);
    // R8: zero gap still leaves one low clock between A and B
    gap_len = 6'd0;
    run_cycle(2'b10, 5, NONE, NONE, NONE);
    check("R8 gap0 A", cnt_a, 5);
    check("R8 gap0 B", cnt_b, 14);
    check("R8 gap0 spacing", b_rise - a_fall, 1);
    check("R8 gap0 overlap", overlap, 0);

    finish_run();
  end

endmodule